// File: doc/BRIEF.md
# Tagged Conversion Result Packer

This block sits between an ADC sequencer and a DMA-style read channel. Each time the sequencer stores a finished conversion in the last-converted-data register, the block formats that result into one transfer item and raises a request toward the read channel. The items come out in the order the sequencer stores them. If the sequencer repeats the same channel pattern on every trigger event, the item pattern in the capture buffer repeats with it.

A tag-enable input selects one of two item formats. With tagging off, the item is a 16-bit half-word that holds the right-aligned result. With tagging on, the item is a 32-bit word that also carries the channel number, so software can decode the buffer and check its integrity after capture.

The DMA side uses a valid/ready handshake. If a new result arrives while the previous item is still waiting, the new result replaces the old one and a sticky overrun flag is raised.

Top module: `tagged_result_packer`

## Requirements
- R1: A store strobe on `res_valid_i` makes `xfer_valid_o` high on the next cycle. The request stays high until a cycle with `xfer_ready_i` high accepts it. Exactly one item is delivered per stored result, in store order.
- R2: Untagged item (tag enable low at the store):
  - `xfer_data_o[11:0]` holds the result.
  - All other bits of `xfer_data_o` are zero.
  - `xfer_wide_o` is 0, which marks a 16-bit item.
- R3: Tagged item (tag enable high at the store):
  - `xfer_data_o[11:0]` holds the result.
  - `xfer_data_o[27:24]` holds the 4-bit channel number.
  - All other bits are zero.
  - `xfer_wide_o` is 1, which marks a 32-bit item.
- R4: The tag enable is sampled only at a store. Changing it while an item is pending leaves that item's format unchanged.
- R5: A store while an item is pending and not accepted in that cycle replaces the pending item with the new one. `ovr_flag_o` goes high on the next cycle and stays high.
- R6: A store in the same cycle that the pending item is accepted is not an overrun. The flag stays low and both items are delivered.
- R7: `ovr_clear_i` clears the overrun flag on the next cycle. If a new overrun occurs in the same cycle as the clear, the flag stays set.
- R8: A synchronous active-high reset clears the pending request, the held item data and the overrun flag.
- R9: While a request waits without acceptance and without a new store, `xfer_data_o` and `xfer_wide_o` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid_i | input | 1 | Result store strobe from the sequencer |
| res_value_i | input | 12 | Converted value |
| res_chan_i | input | 4 | Channel number of the conversion |
| tag_en_i | input | 1 | Item format select: 1 = tagged word, 0 = half-word |
| xfer_ready_i | input | 1 | Read channel accepts the item |
| xfer_valid_o | output | 1 | Transfer request |
| xfer_data_o | output | 32 | Formatted item |
| xfer_wide_o | output | 1 | Item size: 1 = 32-bit, 0 = 16-bit |
| ovr_clear_i | input | 1 | Clear the overrun flag |
| ovr_flag_o | output | 1 | Sticky overrun flag |

## Verification
The bench uses the default parameters: a 12-bit result, a 4-bit channel, and the channel field starting at bit 24. With these values, a full-scale result of 0xFFF and channel 15 fill their fields completely, so any stray bit outside the fields, or any overlap between them, shows up in the item. The same sizes keep the whole 32-bit word visible, so the zero bits between the value field and the channel field can be checked in both formats.

// File: rtl/rpk_pkg.sv
package rpk_pkg;

    localparam int ITEM_W = 32;
    localparam int HALF_W = 16;

    typedef struct packed {
        logic [ITEM_W-1:0] data;
        logic              wide;
    } item_t;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_LOAD,
        ACT_OVERWRITE,
        ACT_DRAIN
    } hold_act_t;

    typedef enum logic {
        HOLD_EMPTY,
        HOLD_FULL
    } hold_state_t;

    function automatic hold_act_t pick_action(input logic store,
                                              input logic full,
                                              input logic ready);
        if (store)
            return (full && !ready) ? ACT_OVERWRITE : ACT_LOAD;
        else if (full && ready)
            return ACT_DRAIN;
        else
            return ACT_IDLE;
    endfunction

endpackage

// File: rtl/rpk_format.sv
module rpk_format
    import rpk_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int CHAN_W   = 4,
    parameter int CHAN_LSB = 24
) (
    input  logic [RES_W-1:0]  value_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic              tag_i,
    output item_t             item_o
);
    localparam int CHAN_TOP = CHAN_LSB + CHAN_W;

    generate
        if (CHAN_TOP <= ITEM_W && RES_W <= HALF_W && RES_W <= CHAN_LSB) begin : g_fit
            always_comb begin
                item_o = '0;
                item_o.data[RES_W-1:0] = value_i;
                item_o.wide = tag_i;
                if (tag_i)
                    item_o.data[CHAN_LSB +: CHAN_W] = chan_i;
            end
        end else begin : g_nofit
            always_comb begin
                item_o = '0;
                item_o.data[RES_W-1:0] = value_i;
                item_o.wide = tag_i;
            end
        end
    endgenerate
endmodule

// File: rtl/rpk_hold.sv
module rpk_hold
    import rpk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  store_i,
    input  item_t item_i,
    input  logic  ready_i,
    output logic  valid_o,
    output item_t item_o,
    output logic  overwrite_o
);
    hold_state_t state_q;
    item_t       item_q;
    hold_act_t   act;

    always_comb begin
        act         = pick_action(store_i, state_q == HOLD_FULL, ready_i);
        overwrite_o = (act == ACT_OVERWRITE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HOLD_EMPTY;
            item_q  <= '0;
        end else begin
            unique case (act)
                ACT_LOAD, ACT_OVERWRITE: begin
                    state_q <= HOLD_FULL;
                    item_q  <= item_i;
                end
                ACT_DRAIN: state_q <= HOLD_EMPTY;
                default:   state_q <= state_q;
            endcase
        end
    end

    assign valid_o = (state_q == HOLD_FULL);
    assign item_o  = item_q;
endmodule

// File: rtl/rpk_overrun.sv
module rpk_overrun (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clear_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clear_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/tagged_result_packer.sv
module tagged_result_packer
    import rpk_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int CHAN_W   = 4,
    parameter int CHAN_LSB = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              res_valid_i,
    input  logic [RES_W-1:0]  res_value_i,
    input  logic [CHAN_W-1:0] res_chan_i,
    input  logic              tag_en_i,
    input  logic              xfer_ready_i,
    output logic              xfer_valid_o,
    output logic [ITEM_W-1:0] xfer_data_o,
    output logic              xfer_wide_o,
    input  logic              ovr_clear_i,
    output logic              ovr_flag_o
);
    item_t fmt_item;
    item_t held_item;
    logic  overwrite;

    rpk_format #(
        .RES_W   (RES_W),
        .CHAN_W  (CHAN_W),
        .CHAN_LSB(CHAN_LSB)
    ) u_format (
        .value_i(res_value_i),
        .chan_i (res_chan_i),
        .tag_i  (tag_en_i),
        .item_o (fmt_item)
    );

    rpk_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .store_i    (res_valid_i),
        .item_i     (fmt_item),
        .ready_i    (xfer_ready_i),
        .valid_o    (xfer_valid_o),
        .item_o     (held_item),
        .overwrite_o(overwrite)
    );

    rpk_overrun u_overrun (
        .clk    (clk),
        .rst    (rst),
        .set_i  (overwrite),
        .clear_i(ovr_clear_i),
        .flag_o (ovr_flag_o)
    );

    assign xfer_data_o = held_item.data;
    assign xfer_wide_o = held_item.wide;
endmodule

// File: rtl/rpk_checker.sv
module rpk_checker #(
    parameter int RES_W = 12,
    parameter int ITEM_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              res_valid_i,
    input logic              xfer_ready_i,
    input logic              xfer_valid_o,
    input logic [ITEM_W-1:0] xfer_data_o,
    input logic              xfer_wide_o,
    input logic              ovr_clear_i,
    input logic              ovr_flag_o
);
    assert_store_requests_R1: assert property (@(posedge clk) disable iff (rst)
        res_valid_i |=> xfer_valid_o);

    assert_no_spurious_request_R1: assert property (@(posedge clk) disable iff (rst)
        (!xfer_valid_o && !res_valid_i) |=> !xfer_valid_o);

    assert_half_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid_o && !xfer_wide_o) |-> (xfer_data_o[ITEM_W-1:RES_W] == '0));

    assert_overrun_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid_o && !xfer_ready_i && res_valid_i) |=> ovr_flag_o);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag_o && !ovr_clear_i) |=> ovr_flag_o);

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (!xfer_valid_o && !ovr_flag_o && xfer_data_o == '0));

    assert_stall_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid_o && !xfer_ready_i && !res_valid_i) |=>
            (xfer_valid_o && $stable(xfer_data_o) && $stable(xfer_wide_o)));
endmodule

bind tagged_result_packer rpk_checker #(
    .RES_W (RES_W),
    .ITEM_W(rpk_pkg::ITEM_W)
) u_rpk_checker (
    .clk         (clk),
    .rst         (rst),
    .res_valid_i (res_valid_i),
    .xfer_ready_i(xfer_ready_i),
    .xfer_valid_o(xfer_valid_o),
    .xfer_data_o (xfer_data_o),
    .xfer_wide_o (xfer_wide_o),
    .ovr_clear_i (ovr_clear_i),
    .ovr_flag_o  (ovr_flag_o)
);

// File: tb/tagged_result_packer_test.sv
`timescale 1ns/1ps
module tagged_result_packer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_valid_i = 1'b0;
    logic [11:0] res_value_i = '0;
    logic [3:0]  res_chan_i = '0;
    logic        tag_en_i = 1'b0;
    logic        xfer_ready_i = 1'b0;
    logic        xfer_valid_o;
    logic [31:0] xfer_data_o;
    logic        xfer_wide_o;
    logic        ovr_clear_i = 1'b0;
    logic        ovr_flag_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [32:0] exp_q[$];

    always #2.5 clk = ~clk;

    tagged_result_packer uut (
        .clk         (clk),
        .rst         (rst),
        .res_valid_i (res_valid_i),
        .res_value_i (res_value_i),
        .res_chan_i  (res_chan_i),
        .tag_en_i    (tag_en_i),
        .xfer_ready_i(xfer_ready_i),
        .xfer_valid_o(xfer_valid_o),
        .xfer_data_o (xfer_data_o),
        .xfer_wide_o (xfer_wide_o),
        .ovr_clear_i (ovr_clear_i),
        .ovr_flag_o  (ovr_flag_o)
    );

    function automatic logic [32:0] model(input logic [11:0] v, input logic [3:0] ch,
                                          input logic tag);
        logic [31:0] w;
        w = {20'h0, v};
        if (tag) w[27:24] = ch;
        return {w, tag};
    endfunction

    task automatic check(input bit ok, input string req, input logic [32:0] act,
                         input logic [32:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One-cycle store; replace=1 drops the pending expected item (overwrite case).
    task automatic store(input logic [11:0] v, input logic [3:0] ch, input logic tag,
                         input bit replace);
        res_valid_i = 1'b1;
        res_value_i = v;
        res_chan_i  = ch;
        tag_en_i    = tag;
        if (replace && exp_q.size() > 0) void'(exp_q.pop_back());
        exp_q.push_back(model(v, ch, tag));
        tick();
        res_valid_i = 1'b0;
    endtask

    // Monitor: a transfer occurs at the next posedge when valid && ready.
    always @(negedge clk) begin
        if (!rst && !done && xfer_valid_o && xfer_ready_i) begin
            logic [32:0] got;
            logic [32:0] exp;
            got = {xfer_data_o, xfer_wide_o};
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected item", got, '0);
            end else begin
                exp = exp_q.pop_front();
                check(got == exp, exp[0] ? "R3 tagged item" : "R2 half-word item", got, exp);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [32:0] held;
        tick(); tick();
        rst = 1'b0;
        #1;
        // R8: reset state
        check(!xfer_valid_o && !ovr_flag_o && xfer_data_o == 0, "R8 reset state",
              {xfer_data_o, xfer_valid_o}, '0);

        // R1, R2: untagged items
        xfer_ready_i = 1'b1;
        store(12'hABC, 4'd3, 1'b0, 0); tick();
        store(12'hFFF, 4'd15, 1'b0, 0); tick();
        store(12'h000, 4'd0, 1'b0, 0); tick();
        // R3: tagged items
        store(12'hFFF, 4'd15, 1'b1, 0); tick();
        store(12'h5A5, 4'd9, 1'b1, 0); tick();
        store(12'h001, 4'd0, 1'b1, 0); tick();

        // R6: back-to-back stores with a ready channel, no overrun
        for (int i = 0; i < 6; i++)
            store(12'(i * 300 + 7), 4'(i), 1'(i % 2), 0);
        tick(); tick();
        check(!ovr_flag_o, "R6 no overrun on accept+store", {32'h0, ovr_flag_o}, '0);
        check(exp_q.size() == 0, "R1 all items delivered", 33'(exp_q.size()), '0);

        // R4, R9: stall with tag change while pending
        xfer_ready_i = 1'b0;
        store(12'h3C3, 4'd12, 1'b1, 0);
        held = {xfer_data_o, xfer_wide_o};
        check(xfer_valid_o, "R1 request raised", {32'h0, xfer_valid_o}, 33'h1);
        tag_en_i = 1'b0;
        tick(); tick(); tick();
        check({xfer_data_o, xfer_wide_o} == model(12'h3C3, 4'd12, 1'b1),
              "R4 tag change ignored while pending", {xfer_data_o, xfer_wide_o},
              model(12'h3C3, 4'd12, 1'b1));
        check({xfer_data_o, xfer_wide_o} == held && xfer_valid_o, "R9 stable while stalled",
              {xfer_data_o, xfer_wide_o}, held);
        xfer_ready_i = 1'b1;
        tick(); tick();

        // R5: overwrite while pending
        xfer_ready_i = 1'b0;
        store(12'h111, 4'd1, 1'b0, 0);
        store(12'h222, 4'd2, 1'b1, 1);
        check(ovr_flag_o, "R5 overrun flag set", {32'h0, ovr_flag_o}, 33'h1);
        check({xfer_data_o, xfer_wide_o} == model(12'h222, 4'd2, 1'b1), "R5 newer item held",
              {xfer_data_o, xfer_wide_o}, model(12'h222, 4'd2, 1'b1));
        xfer_ready_i = 1'b1;
        tick(); tick(); tick();
        check(ovr_flag_o, "R5 flag sticky", {32'h0, ovr_flag_o}, 33'h1);

        // R7: clear, then set-wins
        ovr_clear_i = 1'b1; tick(); ovr_clear_i = 1'b0;
        check(!ovr_flag_o, "R7 clear", {32'h0, ovr_flag_o}, '0);
        xfer_ready_i = 1'b0;
        store(12'h333, 4'd3, 1'b0, 0);
        ovr_clear_i = 1'b1;
        store(12'h444, 4'd4, 1'b0, 1);
        ovr_clear_i = 1'b0;
        check(ovr_flag_o, "R7 set wins over clear", {32'h0, ovr_flag_o}, 33'h1);
        xfer_ready_i = 1'b1;
        tick(); tick();

        // R8: reset while an item is pending
        xfer_ready_i = 1'b0;
        store(12'h777, 4'd7, 1'b1, 0);
        rst = 1'b1; tick(); rst = 1'b0;
        exp_q.delete();
        check(!xfer_valid_o && !ovr_flag_o && xfer_data_o == 0, "R8 reset clears pending",
              {xfer_data_o, xfer_valid_o}, '0);
        xfer_ready_i = 1'b1;
        tick(); tick();
        check(!xfer_valid_o, "R8 no request after reset", {32'h0, xfer_valid_o}, '0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule